// File: doc/BRIEF.md
# Programmable Infrared Carrier Generator

This block makes the modulated drive signal for an infrared remote-control transmitter from the system clock. A three-bit select input picks the carrier period: one of six fixed clock divisors, or a steady-high mode for links that send no carrier. A gate input, driven by the frame timing logic, says when the transmitter is active. While the gate is on, the transmit output carries a pulse train whose high time is about one third of its period, or a steady high level. While the gate is off, the output is low.

The select value is sampled only at the start of a carrier period, so changing it never cuts a pulse short. When the gate turns on, a new period begins at once with its high phase. An active-low indicator output, meant for a "transmitting" lamp, is low in every cycle in which the carrier output is gated on. Both outputs are registered. They change on the clock edge that samples the inputs. Reset is synchronous and active low.

Top module: `irc_carrier_gen`

## Requirements
- R1: While `rstN` is sampled low at a clock edge, that edge sets `remOut` to 0 and `ledN` to 1.
- R2: An edge that samples `gate` low sets `remOut` to 0 and `ledN` to 1.
- R3: Select codes 0, 1, 2, 3, 4 and 5 give carrier periods of 8, 16, 64, 96, 128 and 192 clock cycles. The period is measured from one rising edge of `remOut` to the next while `gate` stays high.
- R4: In each carrier period, `remOut` is high for the first floor(D/3) cycles and low for the rest, where D is the period length. This gives 2/6, 5/11, 21/43, 32/64, 42/86 and 64/128 cycles high/low.
- R5: Select codes 6 and 7 mean no carrier: `remOut` stays high for as long as `gate` is sampled high.
- R6: A new select value takes effect only at the next period boundary. The current period finishes with its old length, and no high pulse shorter than 2 cycles appears while `gate` stays high.
- R7: The first edge that samples `gate` high after it was low starts a fresh period in its high phase, so `remOut` becomes 1.
- R8: `ledN` is 0 after every edge that samples `gate` high, in both carrier and steady modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| divSel | input | 3 | Carrier select: 0..5 pick divisors 8,16,64,96,128,192; 6 and 7 mean steady high |
| gate | input | 1 | Transmit enable from the frame timing logic |
| remOut | output | 1 | Transmit output, active high |
| ledN | output | 1 | Transmit indicator, active low |

## Verification
The assertions check, on every cycle, the properties that depend only on nearby cycles:
- the reset values of both outputs;
- that the gate turning off forces the transmit output low and the indicator high;
- that the gate turning on starts with a high output;
- that the indicator tracks the gate;
- that no high pulse ever falls below two cycles.

The exact period lengths, the one-third high times of each divisor, the steady-high modes and the deferral of a select change to the period boundary can only be shown by the bench's scenarios. There, a behavioural model follows each period with its own counter and compares against the outputs on every clock.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int SEL_W   = 3;
  localparam int MAX_DIV = 192;
  localparam int CNT_W   = $clog2(MAX_DIV);

  typedef logic [SEL_W-1:0] selT;
  typedef logic [CNT_W-1:0] cntT;

  // Control-to-datapath strobes: exactly one is set in every cycle.
  typedef struct packed {
    logic clr;    // gate off: stop and park outputs
    logic start;  // begin a new period, latch select
    logic adv;    // step within current period
  } strobeT;

  function automatic cntT periodLen(selT s);
    case (s)
      3'd0:    periodLen = cntT'(8);
      3'd1:    periodLen = cntT'(16);
      3'd2:    periodLen = cntT'(64);
      3'd3:    periodLen = cntT'(96);
      3'd4:    periodLen = cntT'(128);
      3'd5:    periodLen = cntT'(192);
      default: periodLen = cntT'(1);   // steady high: one-cycle "period"
    endcase
  endfunction

  function automatic cntT highLen(selT s);
    cntT p;
    p = periodLen(s);
    if (p < cntT'(3)) highLen = cntT'(1);
    else              highLen = p / cntT'(3);
  endfunction
endpackage

// File: rtl/irc_ctrl.sv
module irc_ctrl
  import irc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   gate,
  input  logic   lastCycle,
  output strobeT stb
);
  logic running;

  always_ff @(posedge clk) begin
    if (!rstN) running <= 1'b0;
    else       running <= gate;
  end

  always_comb begin
    stb.clr   = !gate;
    stb.start = gate && (!running || lastCycle);
    stb.adv   = gate && running && !lastCycle;
  end
endmodule

// File: rtl/irc_dpath.sv
module irc_dpath
  import irc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  selT    divSel,
  input  strobeT stb,
  output logic   lastCycle,
  output logic   remOut,
  output logic   ledN
);
  localparam cntT ONE = cntT'(1);

  cntT cnt;
  selT curSel;
  cntT cntNext;
  cntT lenM1;

  assign lenM1     = periodLen(curSel) - ONE;
  assign lastCycle = (cnt == lenM1);
  assign cntNext   = cnt + ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      curSel <= '0;
      remOut <= 1'b0;
      ledN   <= 1'b1;
    end else if (stb.clr) begin
      cnt    <= '0;
      remOut <= 1'b0;
      ledN   <= 1'b1;
    end else if (stb.start) begin
      cnt    <= '0;
      curSel <= divSel;
      remOut <= 1'b1;
      ledN   <= 1'b0;
    end else if (stb.adv) begin
      cnt    <= cntNext;
      remOut <= (cntNext < highLen(curSel));
      ledN   <= 1'b0;
    end
  end
endmodule

// File: rtl/irc_carrier_gen.sv
module irc_carrier_gen
  import irc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             gate,
  output logic             remOut,
  output logic             ledN
);
  strobeT stb;
  logic   lastCycle;

  irc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .gate      (gate),
    .lastCycle (lastCycle),
    .stb       (stb)
  );

  irc_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .divSel    (divSel),
    .stb       (stb),
    .lastCycle (lastCycle),
    .remOut    (remOut),
    .ledN      (ledN)
  );
endmodule

// File: rtl/irc_carrier_gen_chk.sv
module irc_carrier_gen_chk (
  input logic clk,
  input logic rstN,
  input logic gate,
  input logic remOut,
  input logic ledN
);
  logic [7:0] hiRun;

  always_ff @(posedge clk) begin
    if (!rstN)              hiRun <= 8'd0;
    else if (!remOut)       hiRun <= 8'd0;
    else if (hiRun != 8'hFF) hiRun <= hiRun + 8'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (!remOut && ledN)); // R1

  AST_GATE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !gate |=> (!remOut && ledN)); // R2

  AST_GATE_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gate) |=> remOut); // R7

  AST_LED_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    gate |=> !ledN); // R8

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(remOut) && $past(gate) && $past(rstN)) |-> (hiRun >= 8'd2)); // R6
endmodule

bind irc_carrier_gen irc_carrier_gen_chk u_chk (.*);

// File: tb/irc_carrier_gen_bench.sv
`timescale 1ns/1ps
module irc_carrier_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] divSel = 3'd0;
  logic       gate = 1'b0;
  logic       remOut, ledN;

  int checks = 0, failures = 0;
  bit done = 0, started = 0;

  always #2.5 clk = ~clk;

  irc_carrier_gen u_irc_carrier_gen (
    .clk(clk), .rstN(rstN), .divSel(divSel), .gate(gate),
    .remOut(remOut), .ledN(ledN)
  );

  function automatic int lenOf(int s);
    case (s)
      0: return 8;   1: return 16;  2: return 64;
      3: return 96;  4: return 128; 5: return 192;
      default: return 1;
    endcase
  endfunction

  function automatic int hiOf(int s);
    if (s > 5) return 1;
    return lenOf(s) / 3;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference: position within the period and latched select.
  int    mPos = 0, mSel = 0;
  bit    mOn = 0, expRem = 0, expLed = 1;
  string tagRem = "R1", tagLed = "R1";

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      mOn = 0; expRem = 0; expLed = 1; tagRem = "R1"; tagLed = "R1";
    end else if (!gate) begin
      mOn = 0; expRem = 0; expLed = 1; tagRem = "R2"; tagLed = "R2";
    end else begin
      bit fresh;
      fresh = !mOn;
      if (!mOn || mPos == lenOf(mSel) - 1) begin
        mOn = 1; mSel = int'(divSel); mPos = 0;
      end else begin
        mPos++;
      end
      expRem = (mPos < hiOf(mSel));
      expLed = 0;
      tagLed = "R8";
      if (fresh)                  tagRem = "R7";
      else if (int'(divSel) != mSel) tagRem = "R6";
      else if (mSel > 5)          tagRem = "R5";
      else                        tagRem = "R4";
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(remOut === expRem, tagRem, int'(remOut), int'(expRem));
      chk(ledN === expLed, tagLed, int'(ledN), int'(expLed));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // R3: period from one rising edge of remOut to the next
  task automatic measure(int sel, int expLen);
    int gap;
    bit prev;
    gate = 1'b0; cyc(2);
    divSel = 3'(sel); gate = 1'b1;
    cyc(1);                       // first edge with gate high -> high
    prev = remOut;
    gap = 0;
    for (int i = 0; i < 400; i++) begin
      cyc(1);
      gap++;
      if (remOut && !prev) break;
      prev = remOut;
    end
    chk(gap == expLen, "R3", gap, expLen);
  endtask

  initial begin
    cyc(3);
    chk(remOut === 1'b0 && ledN === 1'b1, "R1", int'({remOut, ledN}), 1);
    rstN = 1'b1; cyc(2);

    measure(0, 8);   measure(1, 16);  measure(2, 64);
    measure(3, 96);  measure(4, 128); measure(5, 192);

    // R5 steady modes
    gate = 1'b0; cyc(2); divSel = 3'd6; gate = 1'b1; cyc(10);
    divSel = 3'd7; cyc(10);

    // R6: change select mid-period
    gate = 1'b0; cyc(2); divSel = 3'd1; gate = 1'b1; cyc(7);
    divSel = 3'd0; cyc(40);
    divSel = 3'd6; cyc(3); cyc(12);
    divSel = 3'd2; cyc(100);
    divSel = 3'd5; cyc(30); divSel = 3'd3; cyc(300);

    // R2/R7: gate dropped in high phase and short gate pulses
    divSel = 3'd1; gate = 1'b1; cyc(3); gate = 1'b0; cyc(2);
    gate = 1'b1; cyc(1); gate = 1'b0; cyc(1); gate = 1'b1; cyc(20);

    // R1: reset with gate high
    rstN = 1'b0; cyc(2); rstN = 1'b1; cyc(10);
    gate = 1'b0; cyc(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule